// File: doc/BRIEF.md
# Write Strobe Qualifier

This block stands between the host-side control pins of a byte-wide flash array and its command decoder. It watches the sampled chip-enable, output-enable and write-enable lines, the device reset pin and a digital power-good flag. It turns them into one clean write event. A write event is a single-cycle pulse that carries the address and the data belonging to one host write. The block keeps out glitches on the write strobe, writes attempted while the outputs are enabled, and writes made during or just after a power transition.

The write strobe is the time during which both chip-enable and write-enable are low. Its start is the later of the two falling edges and its end is the earlier of the two rising edges. Both the write-enable-timed and the chip-enable-timed host cycles therefore work. A separate filter measures how long the device reset pin is held low. Only a low period that is long enough raises an abort pulse, which stops any operation in progress.

The write event has no ready input. A host strobe cannot be stalled, so the decoder must take every pulse in the cycle it is presented. The valid signal never waits on back-pressure.

Top module: `wpg_front`

## Requirements
- R1: After system reset, wr_valid and abort_o are low.
- R2: A strobe is a run of consecutive sampled cycles in which ce_n and we_n are both 0. A strobe shorter than MIN_WE_CYC cycles produces no write event. A strobe of MIN_WE_CYC cycles or longer produces exactly one write event.
- R3: If oe_n is sampled 0 in any cycle of a strobe, that strobe produces no write event.
- R4: A strobe produces no write event unless pwr_good has been 1 for at least HOLDOFF_CYC consecutive samples before each of its cycles. A sample of pwr_good at 0 restarts this count from zero.
- R5: wr_valid is high for exactly one cycle. That cycle is the one after the first sample in which the strobe is inactive.
- R6: wr_addr holds the addr value of the strobe's first cycle. wr_data holds the din value of the strobe's last cycle.
- R7: Both write styles are accepted. In the first, write-enable falls after chip-enable and rises before it. In the second, chip-enable falls after write-enable and rises before it.
- R8: If dev_rst_n is low for RST_MIN_CYC consecutive samples, abort_o pulses high for exactly one cycle, in the cycle after the RST_MIN_CYC-th low sample. A shorter low period produces no pulse.
- R9: If dev_rst_n is sampled 0 in any cycle of a strobe, that strobe produces no write event.
- R10: rd_en is 1 exactly when dev_rst_n is 1, ce_n is 0, oe_n is 0 and we_n is 1. Once the reset pin is released, the block returns to read or to standby as the control pins select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | System reset, active low |
| ce_n | input | 1 | Sampled chip enable, active low |
| oe_n | input | 1 | Sampled output enable, active low |
| we_n | input | 1 | Sampled write enable, active low |
| dev_rst_n | input | 1 | Device reset pin, active low |
| pwr_good | input | 1 | Supply above its sense level |
| addr | input | ADDR_W | Host address |
| din | input | DATA_W | Host write data |
| wr_valid | output | 1 | Qualified write event, one cycle |
| wr_addr | output | ADDR_W | Address of the write event |
| wr_data | output | DATA_W | Data of the write event |
| abort_o | output | 1 | Long reset seen, one-cycle pulse |
| rd_en | output | 1 | Read output drive enable |

## Verification
The bench builds the block with MIN_WE_CYC = 3, HOLDOFF_CYC = 40 and RST_MIN_CYC = 8. These small values keep the power-on hold-off window and the reset-width threshold short enough to cross many times in one run. They also leave room for strobes of length 2 and 3 and for reset lows of length 7 and 8. Those lengths land just below and exactly on each threshold.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  // width of a counter that must reach the value n
  function automatic int cnt_w(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/wpg_holdoff.sv
module wpg_holdoff #(
  parameter int HOLDOFF_CYC = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  output logic armed
);
  localparam int HW = wpg_pkg::cnt_w(HOLDOFF_CYC);
  localparam logic [HW-1:0] HLIM = HW'(HOLDOFF_CYC);

  logic [HW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            run_q <= '0;
    else if (!pwr_good)    run_q <= '0;
    else if (run_q != HLIM) run_q <= run_q + 1'b1;
  end

  assign armed = pwr_good && (run_q == HLIM);
endmodule

// File: rtl/wpg_rst_filter.sv
module wpg_rst_filter #(
  parameter int RST_MIN_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dev_rst_n,
  output logic abort_o
);
  localparam int RW = wpg_pkg::cnt_w(RST_MIN_CYC);
  localparam logic [RW-1:0] RLIM = RW'(RST_MIN_CYC);

  logic [RW-1:0] low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q   <= '0;
      abort_o <= 1'b0;
    end else if (dev_rst_n) begin
      low_q   <= '0;
      abort_o <= 1'b0;
    end else begin
      abort_o <= (low_q == RLIM - 1'b1);
      if (low_q != RLIM) low_q <= low_q + 1'b1;
    end
  end
endmodule

// File: rtl/wpg_strobe_qual.sv
module wpg_strobe_qual #(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 8,
  parameter int MIN_WE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb,
  input  logic              block,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int WW = wpg_pkg::cnt_w(MIN_WE_CYC);
  localparam logic [WW-1:0] WLIM = WW'(MIN_WE_CYC);

  logic              strb_q;
  logic              spoil_q;
  logic [WW-1:0]     len_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              start, stop;

  assign start = strb && !strb_q;
  assign stop  = !strb && strb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_q  <= 1'b0;
      spoil_q <= 1'b0;
      len_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      strb_q <= strb;
      if (start) begin
        len_q   <= WW'(1);
        spoil_q <= block;
        addr_q  <= addr;
      end else if (strb) begin
        if (len_q != WLIM) len_q <= len_q + 1'b1;
        spoil_q <= spoil_q || block;
      end
      if (strb) data_q <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= stop && !spoil_q && (len_q >= WLIM);
      if (stop) begin
        wr_addr <= addr_q;
        wr_data <= data_q;
      end
    end
  end
endmodule

// File: rtl/wpg_front.sv
module wpg_front #(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 8,
  parameter int MIN_WE_CYC  = 2,
  parameter int HOLDOFF_CYC = 500000,
  parameter int RST_MIN_CYC = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              dev_rst_n,
  input  logic              pwr_good,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              abort_o,
  output logic              rd_en
);
  logic armed;
  logic strb;
  logic block;

  wpg_holdoff #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_holdoff (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .armed(armed)
  );

  wpg_rst_filter #(.RST_MIN_CYC(RST_MIN_CYC)) u_rstf (
    .clk(clk), .rst_n(rst_n), .dev_rst_n(dev_rst_n), .abort_o(abort_o)
  );

  // strobe window: later falling edge, earlier rising edge of ce_n/we_n
  assign strb  = !ce_n && !we_n;
  assign block = !oe_n || !armed || !dev_rst_n;

  wpg_strobe_qual #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_WE_CYC(MIN_WE_CYC)
  ) u_qual (
    .clk(clk), .rst_n(rst_n), .strb(strb), .block(block),
    .addr(addr), .din(din),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign rd_en = dev_rst_n && !ce_n && !oe_n && we_n;
endmodule

// File: rtl/wpg_front_chk.sv
module wpg_front_chk #(
  parameter int HOLDOFF_CYC = 500000
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic we_n,
  input logic dev_rst_n,
  input logic pwr_good,
  input logic wr_valid,
  input logic abort_o
);
  localparam int PW = wpg_pkg::cnt_w(HOLDOFF_CYC);
  localparam logic [PW-1:0] PLIM = PW'(HOLDOFF_CYC);

  logic [PW-1:0] pg_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pg_run <= '0;
    else if (!pwr_good)      pg_run <= '0;
    else if (pg_run != PLIM) pg_run <= pg_run + 1'b1;
  end

  assert_holdoff_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (pg_run == PLIM));

  assert_after_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(ce_n || we_n));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  assert_abort_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> $past(!dev_rst_n));

  assert_abort_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);
endmodule

bind wpg_front wpg_front_chk #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
  .dev_rst_n(dev_rst_n), .pwr_good(pwr_good),
  .wr_valid(wr_valid), .abort_o(abort_o)
);

// File: tb/wpg_front_tb.sv
module wpg_front_tb;
  localparam int AW = 18;
  localparam int DW = 8;
  localparam int MINW = 3;
  localparam int HOLD = 40;
  localparam int RMIN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic dev_rst_n = 1'b1, pwr_good = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic wr_valid, abort_o, rd_en;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int total = 0, bad = 0;
  int nvalid = 0, nabort = 0;
  logic [AW-1:0] last_addr;
  logic [DW-1:0] last_data;

  always #5 clk = ~clk;

  wpg_front #(.ADDR_W(AW), .DATA_W(DW), .MIN_WE_CYC(MINW),
              .HOLDOFF_CYC(HOLD), .RST_MIN_CYC(RMIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .dev_rst_n(dev_rst_n), .pwr_good(pwr_good), .addr(addr), .din(din),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .abort_o(abort_o), .rd_en(rd_en)
  );

  always @(negedge clk) begin
    if (wr_valid) begin
      nvalid++;
      last_addr = wr_addr;
      last_data = wr_data;
    end
    if (abort_o) nabort++;
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // one host write; ce_ctl selects the chip-enable-timed style
  task automatic host_write(input bit ce_ctl, input logic [AW-1:0] a0, a1,
                            input logic [DW-1:0] d0, d1, input int len, input bit oe_dip);
    @(negedge clk);
    if (ce_ctl) we_n = 1'b0; else ce_n = 1'b0;
    for (int i = 0; i < len; i++) begin
      if (i == 0) begin
        if (ce_ctl) ce_n = 1'b0; else we_n = 1'b0;
      end
      addr = (i == 0) ? a0 : a1;
      din  = (i == len - 1) ? d1 : d0;
      oe_n = !(oe_dip && i == len / 2);
      @(negedge clk);
    end
    oe_n = 1'b1;
    if (ce_ctl) ce_n = 1'b1; else we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_state;
    check("R1 wr_valid", wr_valid, 0);
    check("R1 abort_o", abort_o, 0);
  endtask

  task automatic t_holdoff;
    int n0;
    @(negedge clk); pwr_good = 1'b1;
    n0 = nvalid;
    host_write(0, 18'h05555, 18'h00001, 8'h11, 8'hAA, 4, 0);
    check("R4 early write rejected", nvalid - n0, 0);
    repeat (HOLD + 5) @(negedge clk);
    n0 = nvalid;
    host_write(0, 18'h05555, 18'h00001, 8'h11, 8'hAA, 4, 0);
    check("R4 write after hold-off", nvalid - n0, 1);
    // drop power: count restarts
    pwr_good = 1'b0; repeat (2) @(negedge clk); pwr_good = 1'b1;
    n0 = nvalid;
    host_write(0, 18'h00123, 18'h00123, 8'h22, 8'h22, 4, 0);
    check("R4 write after power drop rejected", nvalid - n0, 0);
    repeat (HOLD + 5) @(negedge clk);
  endtask

  task automatic t_width;
    int n0;
    n0 = nvalid;
    host_write(0, 18'h00010, 18'h00010, 8'h01, 8'h01, MINW - 1, 0);
    check("R2 short strobe rejected", nvalid - n0, 0);
    n0 = nvalid;
    host_write(0, 18'h00020, 18'h00020, 8'h02, 8'h02, 1, 0);
    check("R2 one-cycle glitch rejected", nvalid - n0, 0);
    n0 = nvalid;
    host_write(0, 18'h00030, 18'h00030, 8'h03, 8'h03, MINW, 0);
    check("R2 minimum strobe accepted", nvalid - n0, 1);
  endtask

  task automatic t_capture;
    int n0;
    n0 = nvalid;
    host_write(0, 18'h2AAAA, 18'h15555, 8'h5A, 8'hC3, 5, 0);
    check("R5 one pulse", nvalid - n0, 1);
    check("R6 address from first cycle", last_addr, 18'h2AAAA);
    check("R6 data from last cycle", last_data, 8'hC3);
  endtask

  task automatic t_pulse_timing;
    // check exact cycle of wr_valid
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; addr = 18'h00777; din = 8'h77;
    repeat (MINW) @(negedge clk);
    we_n = 1'b1;
    check("R5 not before close", wr_valid, 0);
    @(negedge clk);
    check("R5 high cycle after close", wr_valid, 1);
    @(negedge clk);
    check("R5 low again", wr_valid, 0);
    ce_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_ce_controlled;
    int n0;
    n0 = nvalid;
    host_write(1, 18'h3C001, 18'h00000, 8'h40, 8'h9E, 4, 0);
    check("R7 chip-enable timed write", nvalid - n0, 1);
    check("R7 chip-enable timed addr", last_addr, 18'h3C001);
    check("R7 chip-enable timed data", last_data, 8'h9E);
    n0 = nvalid;
    host_write(1, 18'h00001, 18'h00001, 8'h40, 8'h40, MINW - 1, 0);
    check("R7 short chip-enable strobe rejected", nvalid - n0, 0);
  endtask

  task automatic t_oe_inhibit;
    int n0;
    n0 = nvalid;
    host_write(0, 18'h00444, 18'h00444, 8'h44, 8'h44, 4, 1);
    check("R3 oe low inhibits", nvalid - n0, 0);
  endtask

  task automatic pulse_dev_reset(input int len);
    @(negedge clk); dev_rst_n = 1'b0;
    repeat (len) @(negedge clk);
    dev_rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_dev_reset;
    int a0, n0;
    a0 = nabort;
    pulse_dev_reset(RMIN - 1);
    check("R8 short reset no abort", nabort - a0, 0);
    a0 = nabort;
    pulse_dev_reset(RMIN);
    check("R8 minimum reset aborts", nabort - a0, 1);
    a0 = nabort;
    pulse_dev_reset(RMIN * 3);
    check("R8 long reset one abort", nabort - a0, 1);
    // exact cycle
    @(negedge clk); dev_rst_n = 1'b0;
    repeat (RMIN - 1) @(negedge clk);
    check("R8 no abort before limit", abort_o, 0);
    @(negedge clk);
    check("R8 abort at limit", abort_o, 1);
    @(negedge clk);
    check("R8 abort single cycle", abort_o, 0);
    // R9: write while reset is low
    n0 = nvalid;
    host_write(0, 18'h00099, 18'h00099, 8'h99, 8'h99, 4, 0);
    check("R9 write during reset rejected", nvalid - n0, 0);
    dev_rst_n = 1'b1;
    repeat (2) @(negedge clk);
    n0 = nvalid;
    host_write(0, 18'h00098, 18'h00098, 8'h98, 8'h98, 4, 0);
    check("R9 write after reset release", nvalid - n0, 1);
  endtask

  task automatic t_read_enable;
    @(negedge clk);
    dev_rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #1 check("R10 read off under reset", rd_en, 0);
    @(negedge clk); dev_rst_n = 1'b1;
    #1 check("R10 read after release", rd_en, 1);
    @(negedge clk); ce_n = 1'b1;
    #1 check("R10 standby", rd_en, 0);
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1;
    #1 check("R10 output disabled", rd_en, 0);
    @(negedge clk); ce_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_holdoff();
    t_width();
    t_capture();
    t_pulse_timing();
    t_ce_controlled();
    t_oe_inhibit();
    t_dev_reset();
    t_read_enable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule